// File: doc/BRIEF.md
# Microcoded Control Sequencer for an Accumulator CPU

This block is the control unit of a small 8-bit accumulator processor that moves all data over one shared bus. It takes the 4-bit opcode field of the current instruction and steps a stage counter through six timing slots, T0 to T5. In every slot it produces a 15-bit control word. The word names the single unit allowed to drive the bus and the units that capture the bus on the next rising clock edge. A separate flag reports when the processor has stopped.

The stage counter moves on the falling clock edge, so the control lines are settled half a period before the datapath acts on the rising edge. The first three slots fetch the instruction and are the same for every opcode. The last three slots depend on the opcode. The halt opcode sends the counter into a holding slot that only reset can leave. The control word mixes active-high and active-low lines, and every line that is not asserted rests at its own inactive level.

Top module: `cpu_ctrl_seq`

## Requirements
- R1: Control bit positions, from bit 14 down to bit 0, are: PC increment, PC drive, PC load, address-register load, memory-data load, memory drive, memory write, instruction-register load, instruction-register drive, accumulator load, accumulator drive, subtract select, ALU drive, B-register load, output-register load. Bits 11 to 5, bit 1 and bit 0 are active low. All other bits are active high. A line that is not asserted sits at its inactive level, so the all-idle word is 15'h0FE3.
- R2: The stage advances on the falling clock edge in the order T0, T1, T2, T3, T4, T5 and then wraps back to T0.
- R3: The fetch stages are the same for every opcode. T0 asserts PC drive and address load. T1 asserts PC increment. T2 asserts memory drive and instruction load.
- R4: The load opcode 4 asserts, at T3, instruction-register drive and address load, and at T4, memory drive and accumulator load. The add opcode 2 asserts the same T3 lines, then memory drive and B load at T4, then ALU drive and accumulator load at T5. The subtract opcode 3 is the same as add, except that subtract select is also asserted at T5.
- R5: The output opcode 5 asserts, at T3, accumulator drive and output load. The store opcode 6 asserts, at T3, instruction-register drive and address load, at T4, accumulator drive and memory-data load, and at T5, memory write. The jump opcode 7 asserts, at T3, instruction-register drive and PC load. Every execute stage not listed here is idle.
- R6: Opcode 1 and opcodes 8 to 15 assert only the fetch lines. T3 to T5 are idle for them.
- R7: For opcode 0, the falling edge that ends T2 moves the block into a holding stage. There `halted` is 1 and the control word is idle. The block stays there until reset.
- R8: An asynchronous low level on `rst_n` forces the stage to T0 and clears `halted` at once, without waiting for a clock edge.
- R9: In every stage, at most one of the bus-drive lines (PC drive, memory drive, instruction-register drive, accumulator drive, ALU drive) is active.
- R10: The control word is decoded combinationally from the registered stage and the present opcode, so an opcode change within a stage shows on `ctrl` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stage register moves on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W | Opcode field of the current instruction |
| ctrl | output | 15 | Control word with mixed polarity |
| halted | output | 1 | High while in the holding stage |

## Verification
The bench builds the block with the default OP_W of 4. With that width, all sixteen opcode values can be run through every stage, including the eight unassigned codes that must behave like the no-operation opcode. It compares each stage against an expected table written separately from the RTL. It holds the halt opcode in the holding stage for twelve cycles, and it pulls reset in the middle of a half period to show that reset acts without a clock edge. It also changes the opcode within an execute stage to show that the decode is combinational.

// File: rtl/cpu_ctrl_seq.sv
module cpu_ctrl_seq #(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic [14:0]     ctrl,
  output logic            halted
);

  localparam int B_PCINC = 14;
  localparam int B_PCDRV = 13;
  localparam int B_PCLD  = 12;
  localparam int B_ADRLD = 11;
  localparam int B_MDLD  = 10;
  localparam int B_MEMDRV = 9;
  localparam int B_MEMWR = 8;
  localparam int B_IRLD  = 7;
  localparam int B_IRDRV = 6;
  localparam int B_ACCLD = 5;
  localparam int B_ACCDRV = 4;
  localparam int B_SUBSEL = 3;
  localparam int B_ALUDRV = 2;
  localparam int B_BLD   = 1;
  localparam int B_OUTLD = 0;
  localparam logic [14:0] IDLE_WORD = 15'h0FE3;

  localparam logic [OP_W-1:0] OP_HLT = OP_W'(0);
  localparam logic [OP_W-1:0] OP_ADD = OP_W'(2);
  localparam logic [OP_W-1:0] OP_SUB = OP_W'(3);
  localparam logic [OP_W-1:0] OP_LDA = OP_W'(4);
  localparam logic [OP_W-1:0] OP_OUT = OP_W'(5);
  localparam logic [OP_W-1:0] OP_STA = OP_W'(6);
  localparam logic [OP_W-1:0] OP_JMP = OP_W'(7);

  typedef enum logic [2:0] {
    ST_T0 = 3'd0, ST_T1 = 3'd1, ST_T2 = 3'd2,
    ST_T3 = 3'd3, ST_T4 = 3'd4, ST_T5 = 3'd5,
    ST_HOLD = 3'd6
  } stage_t;

  stage_t stage, stage_nx;
  logic [14:0] act;

  always_comb begin
    case (stage)
      ST_T0:   stage_nx = ST_T1;
      ST_T1:   stage_nx = ST_T2;
      ST_T2:   stage_nx = (opcode == OP_HLT) ? ST_HOLD : ST_T3;
      ST_T3:   stage_nx = ST_T4;
      ST_T4:   stage_nx = ST_T5;
      ST_HOLD: stage_nx = ST_HOLD;
      default: stage_nx = ST_T0;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stage <= ST_T0;
    else        stage <= stage_nx;
  end

  assign halted = (stage == ST_HOLD);

  always_comb begin
    act = '0;
    case (stage)
      ST_T0: begin act[B_PCDRV] = 1'b1; act[B_ADRLD] = 1'b1; end
      ST_T1: act[B_PCINC] = 1'b1;
      ST_T2: begin act[B_MEMDRV] = 1'b1; act[B_IRLD] = 1'b1; end
      ST_T3: begin
        case (opcode)
          OP_ADD, OP_SUB, OP_LDA, OP_STA: begin
            act[B_IRDRV] = 1'b1; act[B_ADRLD] = 1'b1;
          end
          OP_OUT: begin act[B_ACCDRV] = 1'b1; act[B_OUTLD] = 1'b1; end
          OP_JMP: begin act[B_IRDRV] = 1'b1; act[B_PCLD] = 1'b1; end
          default: ;
        endcase
      end
      ST_T4: begin
        case (opcode)
          OP_LDA: begin act[B_MEMDRV] = 1'b1; act[B_ACCLD] = 1'b1; end
          OP_ADD, OP_SUB: begin act[B_MEMDRV] = 1'b1; act[B_BLD] = 1'b1; end
          OP_STA: begin act[B_ACCDRV] = 1'b1; act[B_MDLD] = 1'b1; end
          default: ;
        endcase
      end
      ST_T5: begin
        case (opcode)
          OP_ADD: begin act[B_ALUDRV] = 1'b1; act[B_ACCLD] = 1'b1; end
          OP_SUB: begin
            act[B_ALUDRV] = 1'b1; act[B_ACCLD] = 1'b1; act[B_SUBSEL] = 1'b1;
          end
          OP_STA: act[B_MEMWR] = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign ctrl = act ^ IDLE_WORD;

  logic [4:0] drivers;
  assign drivers = {ctrl[B_PCDRV], ~ctrl[B_MEMDRV], ~ctrl[B_IRDRV],
                    ctrl[B_ACCDRV], ctrl[B_ALUDRV]};

  p_one_driver_r9: assert property (@(negedge clk) disable iff (!rst_n)
    $countones(drivers) <= 1);

  p_halt_sticky_r7: assert property (@(negedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_hold_idle_r7: assert property (@(negedge clk) disable iff (!rst_n)
    halted |-> (ctrl == IDLE_WORD));

  p_halt_entry_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (stage == ST_T2 && opcode == OP_HLT) |=> halted);

  p_wrap_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (stage == ST_T5) |=> (stage == ST_T0));

  p_fetch_no_halt_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (stage == ST_T0 || stage == ST_T1) |=> !halted);

  p_fetch_t0_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (stage == ST_T0) |-> (ctrl[B_PCDRV] && !ctrl[B_ADRLD]));

endmodule

// File: tb/cpu_ctrl_seq_tb.sv
`timescale 1ns/1ps
module cpu_ctrl_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic [14:0] ctrl;
  logic        halted;
  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;

  localparam logic [14:0] IDLE = 15'h0FE3;

  always #2 clk = ~clk;

  cpu_ctrl_seq #(.OP_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .ctrl(ctrl), .halted(halted)
  );

  function automatic logic [14:0] exp_word(input logic [3:0] op, input int s);
    logic [14:0] m;
    m = '0;
    case (s)
      0: begin m[13] = 1; m[11] = 1; end
      1: m[14] = 1;
      2: begin m[9] = 1; m[7] = 1; end
      3: case (op)
           4'd2, 4'd3, 4'd4, 4'd6: begin m[6] = 1; m[11] = 1; end
           4'd5: begin m[4] = 1; m[0] = 1; end
           4'd7: begin m[6] = 1; m[12] = 1; end
           default: ;
         endcase
      4: case (op)
           4'd4: begin m[9] = 1; m[5] = 1; end
           4'd2, 4'd3: begin m[9] = 1; m[1] = 1; end
           4'd6: begin m[4] = 1; m[10] = 1; end
           default: ;
         endcase
      5: case (op)
           4'd2: begin m[2] = 1; m[5] = 1; end
           4'd3: begin m[2] = 1; m[5] = 1; m[3] = 1; end
           4'd6: m[8] = 1;
           default: ;
         endcase
      default: ;
    endcase
    return m ^ IDLE;
  endfunction

  task automatic chk(input string req, input logic [14:0] ew, input logic eh);
    int nd;
    checks++;
    if (ctrl !== ew || halted !== eh) begin
      fails++;
      $display("FAIL %s: ctrl=%h halted=%b expected ctrl=%h halted=%b", req, ctrl, halted, ew, eh);
    end
    nd = int'(ctrl[13]) + int'(!ctrl[9]) + int'(!ctrl[6]) + int'(ctrl[4]) + int'(ctrl[2]);
    checks++;
    if (nd > 1) begin
      fails++;
      $display("FAIL R9: %0d bus drivers active, expected at most 1", nd);
    end
  endtask

  function automatic string req_of(input logic [3:0] op, input int s);
    if (s < 3) return "R3";
    case (op)
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5, 4'd6, 4'd7: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic start_op(input logic [3:0] op);
    rst_n = 1'b0;
    opcode = op;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic test_reset_state();
    rst_n = 1'b0;
    opcode = 4'd4;
    repeat (3) @(posedge clk);
    #1 chk("R8 reset holds T0", exp_word(4'd4, 0), 1'b0);
  endtask

  task automatic test_opcode(input logic [3:0] op);
    start_op(op);
    for (int s = 0; s < 6; s++) begin
      chk({req_of(op, s), " R1 R2 stage"}, exp_word(op, s), 1'b0);
      @(posedge clk); #1;
    end
    chk("R2 wrap to T0", exp_word(op, 0), 1'b0);
  endtask

  task automatic test_halt();
    start_op(4'd0);
    for (int s = 0; s < 3; s++) begin
      chk("R3 HLT fetch", exp_word(4'd0, s), 1'b0);
      @(posedge clk); #1;
    end
    opcode = 4'd2;
    for (int k = 0; k < 12; k++) begin
      chk("R7 hold frozen", IDLE, 1'b1);
      @(posedge clk); #1;
    end
    rst_n = 1'b0;
    #0.5 chk("R8 async reset leaves hold", exp_word(4'd2, 0), 1'b0);
  endtask

  task automatic test_comb_decode();
    start_op(4'd4);
    repeat (3) @(posedge clk);
    #1 chk("R10 LDA T3", exp_word(4'd4, 3), 1'b0);
    opcode = 4'd5;
    #0.2 chk("R10 opcode swap to OUT in T3", exp_word(4'd5, 3), 1'b0);
    opcode = 4'd9;
    #0.2 chk("R10 R6 opcode swap to 9 in T3", IDLE, 1'b0);
  endtask

  initial begin
    test_reset_state();
    for (int op = 1; op < 16; op++) test_opcode(4'(op));
    test_halt();
    test_comb_decode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule